// File: doc/BRIEF.md
# Receive Frame Length Counter

This block measures the length of each frame that arrives on one receive channel and reports it to a host once the frame has ended. A byte strobe from the deframer advances a running count. A frame-end strobe hands that count to a set of held registers and raises a one-cycle end-of-frame interrupt. The host reads a 13-bit length, an overflow flag and the number of bytes still waiting in the receive FIFO for its final read. It then releases the result with an acknowledge pulse.

Counting only takes place while the channel is in transparent operation. The running count is kept apart from the held result, so the next frame can be counted while the host still owns the previous one. The FIFO threshold can be set to 8, 16, 32 or 64 bytes. Because each of these is a power of two, the leftover byte count is found by masking the low bits of the held length. When that remainder is zero, the full threshold is reported instead.

Top module: `rx_frame_len_counter`

## Requirements
- R1: While `transparent_en` is 1, every cycle with `byte_vld` = 1 adds one byte to the running count, including a byte strobed in the same cycle as `frame_end`.
- R2: On `frame_end` with a nonzero running count and no unacknowledged result held, the count is reported on the next cycle as `len_hi` (bits 12 to 8) and `len_lo` (bits 7 to 0), and `eof_irq` is 1 for exactly that one cycle.
- R3: While a result is held and `host_ack` is 0, the length, `len_ovf` and `eof_irq` do not change. A frame that ends in that time is discarded, and the running count restarts from zero.
- R4: `host_ack` clears the length and `len_ovf` to zero on the next cycle. If `frame_end` occurs in the same cycle as `host_ack`, the new frame is captured instead.
- R5: The 8192nd byte of a frame sets the overflow condition, and the count saturates at 8191. Such a frame reports a length of 8191 with `len_ovf` = 1.
- R6: A `frame_end` with a running count of zero captures nothing and raises no `eof_irq`.
- R7: `thresh_sel` codes 0, 1, 2 and 3 select thresholds of 8, 16, 32 and 64. `fifo_avail` is the held length modulo the threshold, or the threshold itself when that remainder is zero. It is 0 while no result is held.
- R8: While `transparent_en` is 0, `byte_vld` and `frame_end` have no effect.
- R9: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| transparent_en | input | 1 | Counting enabled (transparent operation) |
| byte_vld | input | 1 | One received byte this cycle |
| frame_end | input | 1 | Current frame ends this cycle |
| host_ack | input | 1 | Host releases the held result |
| thresh_sel | input | 2 | FIFO threshold code: 0=8, 1=16, 2=32, 3=64 |
| len_lo | output | 8 | Held length, bits 7 to 0 |
| len_hi | output | 5 | Held length, bits 12 to 8 |
| len_ovf | output | 1 | Held frame reached 8192 bytes or more |
| eof_irq | output | 1 | One-cycle end-of-frame interrupt |
| fifo_avail | output | 7 | Bytes left in the FIFO for the final read |

## Verification
The checker watches several properties on every cycle:
- The held length and flag stay frozen between interrupt and acknowledge.
- An acknowledge leaves the flag clear.
- An interrupt never reports an empty frame.
- An overflowed frame always shows the saturated length.
- The FIFO figure never exceeds the selected threshold.

Only the bench's scenarios can show the rest:
- Exact byte counts, including the byte strobed with frame end.
- The discard of a frame that ends while a result is still held.
- An acknowledge coinciding with a frame end.
- Strobes being ignored outside transparent operation.
- The remainder rule across all four thresholds.
- Saturation after more than 8192 bytes.

// File: rtl/rflc_pkg.sv
// Package rflc_pkg
// Shared types and sizing constants for the receive frame length counter.
// Assumes every threshold is a power of two starting at 2**THR_MIN_LOG2.
package rflc_pkg;
    localparam int THR_MIN_LOG2 = 3;

    typedef enum logic [1:0] {
        THR_8  = 2'd0,
        THR_16 = 2'd1,
        THR_32 = 2'd2,
        THR_64 = 2'd3
    } thr_sel_e;
endpackage

// File: rtl/rflc_run_counter.sv
// Module rflc_run_counter
// Counts the bytes of the frame currently being received, and offers the count
// including this cycle's byte so the frame end can capture it. Saturates at the
// all-ones value and latches an overflow flag instead of wrapping.
// Assumes count_en and frame_done are already qualified by transparent mode.
module rflc_run_counter #(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             frame_done,
    output logic [LEN_W-1:0] nxt_cnt,
    output logic             nxt_ovf
);
    localparam logic [LEN_W-1:0] CNT_MAX = '1;

    logic [LEN_W-1:0] run_cnt;
    logic             run_ovf;

    // Count including this cycle's byte, saturating at CNT_MAX.
    always_comb begin
        nxt_cnt = run_cnt;
        nxt_ovf = run_ovf;
        if (count_en) begin
            if (run_cnt == CNT_MAX) begin
                nxt_ovf = 1'b1;
            end else begin
                nxt_cnt = run_cnt + 1'b1;
            end
        end
    end

    // Running state: restart at a frame end, otherwise take the next count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            run_ovf <= 1'b0;
        end else if (frame_done) begin
            run_cnt <= '0;
            run_ovf <= 1'b0;
        end else begin
            run_cnt <= nxt_cnt;
            run_ovf <= nxt_ovf;
        end
    end
endmodule

// File: rtl/rflc_hold_regs.sv
// Module rflc_hold_regs
// Holds the length and overflow of the last completed frame for the host, and
// raises a one-cycle interrupt when a new result is loaded. A held result is
// frozen until acknowledged. Empty frames are never loaded.
// Assumes frame_done is already qualified by transparent mode.
module rflc_hold_regs #(
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic [LEN_W-1:0] cap_len,
    input  logic             cap_ovf,
    input  logic             host_ack,
    output logic [LEN_W-1:0] held_len,
    output logic             held_ovf,
    output logic             held_vld,
    output logic             irq
);
    logic take;

    // Load when a non-empty frame ends and the slot is free or being released.
    always_comb take = frame_done && (cap_len != '0) && (!held_vld || host_ack);

    // Held result: load on take, clear on acknowledge, otherwise freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_len <= '0;
            held_ovf <= 1'b0;
            held_vld <= 1'b0;
        end else if (take) begin
            held_len <= cap_len;
            held_ovf <= cap_ovf;
            held_vld <= 1'b1;
        end else if (host_ack) begin
            held_len <= '0;
            held_ovf <= 1'b0;
            held_vld <= 1'b0;
        end
    end

    // Interrupt pulse: one cycle, aligned with the newly loaded result.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= take;
    end
endmodule

// File: rtl/rflc_fifo_calc.sv
// Module rflc_fifo_calc
// Works out how many bytes of the held frame remain in the receive FIFO: the
// length modulo the selected threshold, or the full threshold when the
// remainder is zero. Power-of-two thresholds reduce the modulo to a mask.
// Assumes LEN_W is at least AVAIL_W-1.
module rflc_fifo_calc
    import rflc_pkg::*;
#(
    parameter int LEN_W   = 13,
    parameter int SEL_W   = 2,
    parameter int AVAIL_W = THR_MIN_LOG2 + (1 << SEL_W)
) (
    input  logic [LEN_W-1:0]   held_len,
    input  logic               held_vld,
    input  logic [SEL_W-1:0]   sel,
    output logic [AVAIL_W-1:0] avail
);
    logic [AVAIL_W-1:0] thr;
    logic [AVAIL_W-1:0] rem;

    // Remainder by masking with threshold minus one.
    always_comb begin
        thr   = AVAIL_W'(1) << (THR_MIN_LOG2 + int'(sel));
        rem   = {1'b0, held_len[AVAIL_W-2:0]} & (thr - 1'b1);
        avail = !held_vld      ? '0  :
                (rem != '0)    ? rem : thr;
    end
endmodule

// File: rtl/rx_frame_len_counter.sv
// Module rx_frame_len_counter
// Top level: qualifies strobes with transparent mode, counts the running frame,
// holds the finished frame's length for the host and reports FIFO leftovers.
// Assumes LEN_W = 13 so the length splits into an 8-bit and a 5-bit field.
module rx_frame_len_counter
    import rflc_pkg::*;
#(
    parameter int LEN_W   = 13,
    parameter int SEL_W   = 2,
    parameter int LO_W    = 8,
    parameter int HI_W    = LEN_W - LO_W,
    parameter int AVAIL_W = THR_MIN_LOG2 + (1 << SEL_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               transparent_en,
    input  logic               byte_vld,
    input  logic               frame_end,
    input  logic               host_ack,
    input  logic [SEL_W-1:0]   thresh_sel,
    output logic [LO_W-1:0]    len_lo,
    output logic [HI_W-1:0]    len_hi,
    output logic               len_ovf,
    output logic               eof_irq,
    output logic [AVAIL_W-1:0] fifo_avail
);
    logic             cnt_en;
    logic             fr_done;
    logic [LEN_W-1:0] nxt_cnt;
    logic             nxt_ovf;
    logic [LEN_W-1:0] held_len;
    logic             held_vld;

    // Strobes only count in transparent mode.
    always_comb begin
        cnt_en  = transparent_en && byte_vld;
        fr_done = transparent_en && frame_end;
    end

    rflc_run_counter #(.LEN_W(LEN_W)) i_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en   (cnt_en),
        .frame_done (fr_done),
        .nxt_cnt    (nxt_cnt),
        .nxt_ovf    (nxt_ovf)
    );

    rflc_hold_regs #(.LEN_W(LEN_W)) i_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (fr_done),
        .cap_len    (nxt_cnt),
        .cap_ovf    (nxt_ovf),
        .host_ack   (host_ack),
        .held_len   (held_len),
        .held_ovf   (len_ovf),
        .held_vld   (held_vld),
        .irq        (eof_irq)
    );

    rflc_fifo_calc #(.LEN_W(LEN_W), .SEL_W(SEL_W), .AVAIL_W(AVAIL_W)) i_fifo (
        .held_len (held_len),
        .held_vld (held_vld),
        .sel      (thresh_sel),
        .avail    (fifo_avail)
    );

    // Split the held length into the host's low and high fields.
    always_comb begin
        len_lo = held_len[LO_W-1:0];
        len_hi = held_len[LEN_W-1:LO_W];
    end
endmodule

// File: rtl/rflc_checker.sv
// Module rflc_checker
// Port-level properties for rx_frame_len_counter, bound to every instance.
module rflc_checker #(
    parameter int SEL_W   = 2,
    parameter int LO_W    = 8,
    parameter int HI_W    = 5,
    parameter int AVAIL_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               transparent_en,
    input logic               frame_end,
    input logic               host_ack,
    input logic [SEL_W-1:0]   thresh_sel,
    input logic [LO_W-1:0]    len_lo,
    input logic [HI_W-1:0]    len_hi,
    input logic               len_ovf,
    input logic               eof_irq,
    input logic [AVAIL_W-1:0] fifo_avail
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(host_ack) && !eof_irq) |-> $stable({len_hi, len_lo, len_ovf})); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !(frame_end && transparent_en)) |=> (!len_ovf && !eof_irq && {len_hi, len_lo} == '0)); // R4

    AST_IRQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        eof_irq |-> ({len_hi, len_lo} != '0)); // R6

    AST_OVF_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
        len_ovf |-> (&{len_hi, len_lo})); // R5

    AST_AVAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_avail) <= (8 << thresh_sel)); // R7
endmodule

bind rx_frame_len_counter rflc_checker #(
    .SEL_W(SEL_W), .LO_W(LO_W), .HI_W(HI_W), .AVAIL_W(AVAIL_W)
) i_rflc_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .transparent_en (transparent_en),
    .frame_end      (frame_end),
    .host_ack       (host_ack),
    .thresh_sel     (thresh_sel),
    .len_lo         (len_lo),
    .len_hi         (len_hi),
    .len_ovf        (len_ovf),
    .eof_irq        (eof_irq),
    .fifo_avail     (fifo_avail)
);

// File: tb/test_rx_frame_len_counter.sv
// Bench for rx_frame_len_counter: behavioural reference model compared every
// cycle, plus directed checks per requirement.
module test_rx_frame_len_counter;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       transparent_en = 1'b1;
    logic       byte_vld = 1'b0;
    logic       frame_end = 1'b0;
    logic       host_ack = 1'b0;
    logic [1:0] thresh_sel = 2'd0;
    logic [7:0] len_lo;
    logic [4:0] len_hi;
    logic       len_ovf;
    logic       eof_irq;
    logic [6:0] fifo_avail;

    int n_cmp = 0;
    int n_bad = 0;

    rx_frame_len_counter i_rx_frame_len_counter (
        .clk(clk), .rst_n(rst_n), .transparent_en(transparent_en),
        .byte_vld(byte_vld), .frame_end(frame_end), .host_ack(host_ack),
        .thresh_sel(thresh_sel), .len_lo(len_lo), .len_hi(len_hi),
        .len_ovf(len_ovf), .eof_irq(eof_irq), .fifo_avail(fifo_avail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    int m_run = 0, m_len = 0;
    bit m_rovf = 0, m_hovf = 0, m_hval = 0, m_irq = 0, started = 0;

    always @(posedge clk) begin
        int nrun;
        bit nrov;
        started = 1;
        if (!rst_n) begin
            m_run = 0; m_rovf = 0; m_len = 0; m_hovf = 0; m_hval = 0; m_irq = 0;
        end else begin
            nrun = m_run; nrov = m_rovf; m_irq = 0;
            if (transparent_en && byte_vld) begin
                if (m_run == 8191) nrov = 1; else nrun = m_run + 1;
            end
            if (host_ack) begin m_len = 0; m_hovf = 0; m_hval = 0; end
            if (transparent_en && frame_end) begin
                if (nrun != 0 && !m_hval) begin
                    m_len = nrun; m_hovf = nrov; m_hval = 1; m_irq = 1;
                end
                nrun = 0; nrov = 0;
            end
            m_run = nrun; m_rovf = nrov;
        end
    end

    function automatic int exp_avail();
        int thr = 8 << thresh_sel;
        int r = m_len % thr;
        if (!m_hval) return 0;
        return (r != 0) ? r : thr;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            chk({len_hi, len_lo} == m_len, "R2 length", int'({len_hi, len_lo}), m_len);
            chk(len_ovf == m_hovf, "R5 overflow", int'(len_ovf), int'(m_hovf));
            chk(eof_irq == m_irq, "R2 interrupt", int'(eof_irq), int'(m_irq));
            chk(int'(fifo_avail) == exp_avail(), "R7 fifo_avail", int'(fifo_avail), exp_avail());
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic send(input int n);
        byte_vld = 1;
        repeat (n) step();
        byte_vld = 0;
    endtask

    task automatic end_frame(input bit with_byte, input bit with_ack);
        byte_vld = with_byte; frame_end = 1; host_ack = with_ack;
        step();
        byte_vld = 0; frame_end = 0; host_ack = 0;
    endtask

    task automatic ack();
        host_ack = 1; step(); host_ack = 0;
    endtask

    function automatic int len_now();
        return int'({len_hi, len_lo});
    endfunction

    initial begin
        repeat (3) step();
        chk(len_now() == 0 && !len_ovf && !eof_irq && fifo_avail == 0, "R9 reset", len_now(), 0);
        rst_n = 1; step();

        // R1/R2/R7: 5-byte frame, threshold 8
        send(5); end_frame(0, 0);
        chk(len_now() == 5, "R2 length 5", len_now(), 5);
        chk(eof_irq == 1, "R2 irq pulse", int'(eof_irq), 1);
        chk(fifo_avail == 5, "R7 rem 5 of 8", int'(fifo_avail), 5);
        step();
        chk(eof_irq == 0, "R2 irq one cycle", int'(eof_irq), 0);
        ack();
        chk(len_now() == 0, "R4 ack clears", len_now(), 0);

        // R1: byte with frame end counts; threshold 16 -> full threshold
        thresh_sel = 2'd1;
        send(15); end_frame(1, 0);
        chk(len_now() == 16, "R1 frame-end byte", len_now(), 16);
        chk(fifo_avail == 16, "R7 zero remainder", int'(fifo_avail), 16);

        // R3: frame ending while held is discarded
        send(3); end_frame(0, 0);
        chk(len_now() == 16 && eof_irq == 0, "R3 held frozen", len_now(), 16);
        thresh_sel = 2'd2; #1;
        chk(fifo_avail == 16, "R7 thr 32", int'(fifo_avail), 16);
        thresh_sel = 2'd0; #1;
        chk(fifo_avail == 8, "R7 thr 8 zero rem", int'(fifo_avail), 8);

        // R4: ack together with frame end captures the new frame
        send(70); end_frame(0, 1);
        chk(len_now() == 70 && eof_irq == 1, "R4 ack with frame end", len_now(), 70);
        thresh_sel = 2'd3; #1;
        chk(fifo_avail == 6, "R7 thr 64", int'(fifo_avail), 6);
        ack();

        // R6: empty frame end is ignored
        end_frame(0, 0);
        chk(len_now() == 0 && eof_irq == 0, "R6 empty frame", len_now(), 0);

        // R8: strobes ignored outside transparent mode
        transparent_en = 0;
        send(10); end_frame(0, 0);
        chk(eof_irq == 0 && len_now() == 0, "R8 no capture", len_now(), 0);
        transparent_en = 1;
        send(2); end_frame(0, 0);
        chk(len_now() == 2, "R8 bytes not counted", len_now(), 2);
        ack();

        // R5: overflow and saturation
        send(8200); end_frame(0, 0);
        chk(len_now() == 8191, "R5 saturated length", len_now(), 8191);
        chk(len_ovf == 1, "R5 overflow flag", int'(len_ovf), 1);
        chk(fifo_avail == 63, "R7 rem of saturated", int'(fifo_avail), 63);
        ack();
        chk(len_ovf == 0, "R4 ack clears overflow", int'(len_ovf), 0);

        // R5 boundary: exactly 8191 bytes is no overflow
        send(8191); end_frame(0, 0);
        chk(len_now() == 8191 && len_ovf == 0, "R5 8191 no overflow", int'(len_ovf), 0);
        ack();

        repeat (2) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule